// File: doc/BRIEF.md
# Thermistor Tracking Converter with Thermal Derating

This block measures the resistance of an external thermistor network by closed-loop tracking. It drives an 8-bit code into an external current DAC that forces current into the thermistor. A comparator reports whether the resulting pin voltage is above or below a fixed reference. The block nudges the code one LSB at a time until the two balance. A larger code means more current is needed to reach the reference, so the resistance is lower and the temperature is higher. The code is roughly 4,000,000 divided by the network resistance in ohms.

Two first-order low-pass filters smooth the code. The fast filter drives an over-temperature shutdown flag with hysteresis and a startup permit. The power stages may run only once that filtered reading has fallen below the recovery level. The slow filter has a time constant of about two seconds at the half-line-cycle rate, and it drives a linear derating of the requested dim level. In normal operation the tracker moves only once every seventh half line cycle. A startup mode lets it step on every clock so that it settles quickly.

Top module: `thermal_track_derate`

## Requirements
- R1: Each update moves the DAC code by exactly one LSB. Comparator input 1 (pin above reference) decrements the code, and 0 increments it.
- R2: With the startup mode input low, the code updates once per seven half-cycle strobes, on the seventh strobe, and never without a strobe. With startup mode high, it updates on every clock, and the strobe count restarts from zero.
- R3: The code saturates at 0 and at 255. A step past either end leaves it unchanged.
- R4: The fast filter computes acc = acc + code - (acc >> 3) on every code update and is reset to all ones, so its output reads 255. The slow filter computes the same with a shift of 8 on every half-cycle strobe and is reset to zero. Each filter's output is acc >> shift.
- R5: The run permit is low from reset until the fast filtered code is below the recovery code (default 222). After that the permit equals the inverse of the fault flag.
- R6: After the permit has first been granted, a fast filtered code above the shutdown code (default 250) sets the fault flag. The flag clears only when that value drops below the recovery code. Tracking continues while the flag is set.
- R7: Let s be the slow filtered code. If s <= 197, the scaled dim level equals the request. If s >= 242, it equals request >> 1. Between these, it is (request * (256 - (((s - 197) * 728) >> 8))) >> 8.
- R8: After reset the code is 0, the fault flag and permit are 0, and the scaled dim level equals the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, asynchronous assert |
| cmp_above_i | input | 1 | 1 when the thermistor pin voltage is above the reference |
| half_cyc_i | input | 1 | One-clock strobe per rectified half line cycle |
| fast_mode_i | input | 1 | Startup mode: code steps on every clock |
| dim_i | input | DIM_W | Requested dim level |
| dac_code_o | output | 8 | Code driving the thermistor current DAC |
| ot_fault_o | output | 1 | Over-temperature shutdown flag |
| run_ok_o | output | 1 | Permit for the power stages |
| dim_o | output | DIM_W | Dim level after thermal derating |

## Verification
A held-low comparator in startup mode shows that the code counts up once per clock and stops at 255. A held-high comparator shows the count down to 0 and the hold there. Normal mode with strobes spaced by idle clocks shows that only the seventh strobe moves the code and that idle clocks never do. A climb to full scale followed by a descent checks the hysteresis band: the flag must stay set between the recovery and shutdown codes while the code keeps moving. A long strobed run at full scale walks the slow filter through the region below the knee, through the linear ramp and into the half-scale floor. It is checked with several request values, including 0 and full scale.

// File: rtl/thd_pkg.sv
package thd_pkg;
  localparam int CODE_W = 8;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/thd_tracker.sv
module thd_tracker
  import thd_pkg::*;
#(
  parameter int STEP_DIV = 7
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmp_above_i,
  input  logic  half_cyc_i,
  input  logic  fast_mode_i,
  output code_t code_o,
  output logic  tick_o
);
  localparam int CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STEP_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  code_t code_q, code_d;
  logic tick;

  // update event: every clock at startup, else on the last strobe of the group
  assign tick = fast_mode_i | (half_cyc_i & (cnt_q == CNT_LAST));

  always_comb begin
    cnt_d = cnt_q;
    if (fast_mode_i) begin
      cnt_d = '0;
    end else if (half_cyc_i) begin
      cnt_d = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    code_d = code_q;
    if (tick) begin
      if (cmp_above_i) begin
        if (code_q != '0) code_d = code_q - 1'b1;
      end else begin
        if (code_q != code_t'(CODE_MAX)) code_d = code_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      code_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      code_q <= code_d;
    end
  end

  assign code_o = code_q;
  assign tick_o = tick;
endmodule

// File: rtl/thd_iir.sv
module thd_iir
  import thd_pkg::*;
#(
  parameter int SHIFT  = 3,
  parameter bit RST_HI = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  code_t x_i,
  output code_t y_o
);
  localparam int ACC_W = CODE_W + SHIFT;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + (ACC_W+1)'(x_i) - (ACC_W+1)'(acc_q >> SHIFT);
    acc_d = en_i ? sum[ACC_W-1:0] : acc_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= RST_HI ? '1 : '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  assign y_o = acc_q[ACC_W-1:SHIFT];
endmodule

// File: rtl/thd_derate.sv
module thd_derate
  import thd_pkg::*;
#(
  parameter int DIM_W     = 10,
  parameter int DER_START = 197,
  parameter int DER_END   = 242
) (
  input  code_t            lvl_i,
  input  logic [DIM_W-1:0] dim_i,
  output logic [DIM_W-1:0] dim_o
);
  localparam int ONE_Q  = 256;
  localparam int HALF_Q = ONE_Q / 2;
  localparam int SPAN   = DER_END - DER_START;
  localparam int SLOPE  = (HALF_Q * ONE_Q) / SPAN;
  localparam code_t START_C = code_t'(DER_START);
  localparam code_t END_C   = code_t'(DER_END);

  logic [8:0]       scale;
  logic [31:0]      red;
  logic [DIM_W+8:0] prod;

  always_comb begin
    red = '0;
    if (lvl_i <= START_C) begin
      scale = 9'(ONE_Q);
    end else if (lvl_i >= END_C) begin
      scale = 9'(HALF_Q);
    end else begin
      red   = ((32'(lvl_i) - 32'(DER_START)) * 32'(SLOPE)) >> 8;
      scale = 9'(32'(ONE_Q) - red);
    end
    prod = (DIM_W+9)'(dim_i) * (DIM_W+9)'(scale);
  end

  assign dim_o = prod[DIM_W+7:8];
endmodule

// File: rtl/thermal_track_derate.sv
module thermal_track_derate
  import thd_pkg::*;
#(
  parameter int STEP_DIV  = 7,
  parameter int FAST_SH   = 3,
  parameter int SLOW_SH   = 8,
  parameter int DIM_W     = 10,
  parameter int DER_START = 197,
  parameter int DER_END   = 242,
  parameter int SHUT_CODE = 250,
  parameter int REC_CODE  = 222
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_above_i,
  input  logic             half_cyc_i,
  input  logic             fast_mode_i,
  input  logic [DIM_W-1:0] dim_i,
  output logic [7:0]       dac_code_o,
  output logic             ot_fault_o,
  output logic             run_ok_o,
  output logic [DIM_W-1:0] dim_o
);
  localparam code_t SHUT_C = code_t'(SHUT_CODE);
  localparam code_t REC_C  = code_t'(REC_CODE);

  code_t code, filt_fast, filt_slow;
  logic  tick;
  logic  started_q, started_d, fault_q, fault_d;

  thd_tracker #(.STEP_DIV(STEP_DIV)) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni), .cmp_above_i(cmp_above_i),
    .half_cyc_i(half_cyc_i), .fast_mode_i(fast_mode_i),
    .code_o(code), .tick_o(tick)
  );

  // fast path starts hot so nothing runs before a real reading exists
  thd_iir #(.SHIFT(FAST_SH), .RST_HI(1'b1)) u_fast (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(tick), .x_i(code), .y_o(filt_fast)
  );

  thd_iir #(.SHIFT(SLOW_SH), .RST_HI(1'b0)) u_slow (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(half_cyc_i), .x_i(code), .y_o(filt_slow)
  );

  always_comb begin
    started_d = started_q | (filt_fast < REC_C);
    fault_d   = fault_q;
    if (started_q && (filt_fast > SHUT_C)) begin
      fault_d = 1'b1;
    end else if (filt_fast < REC_C) begin
      fault_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      fault_q   <= 1'b0;
    end else begin
      started_q <= started_d;
      fault_q   <= fault_d;
    end
  end

  thd_derate #(.DIM_W(DIM_W), .DER_START(DER_START), .DER_END(DER_END)) u_der (
    .lvl_i(filt_slow), .dim_i(dim_i), .dim_o(dim_o)
  );

  assign dac_code_o = code;
  assign ot_fault_o = fault_q;
  assign run_ok_o   = started_q & ~fault_q;
endmodule

// File: rtl/thd_checker.sv
module thd_checker #(
  parameter int DIM_W     = 10,
  parameter int SHUT_CODE = 250,
  parameter int REC_CODE  = 222
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmp_above_i,
  input logic             half_cyc_i,
  input logic             fast_mode_i,
  input logic [DIM_W-1:0] dim_i,
  input logic [7:0]       dac_code_o,
  input logic             ot_fault_o,
  input logic             run_ok_o,
  input logic [DIM_W-1:0] dim_o,
  input logic [7:0]       filt_fast
);
  // R1: never more than one LSB per clock
  a_r1_single_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (9'(dac_code_o) <= 9'($past(dac_code_o)) + 9'd1) &&
    (9'($past(dac_code_o)) <= 9'(dac_code_o) + 9'd1));

  // R2: no strobe and no startup mode keeps the code
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fast_mode_i && !half_cyc_i) |=> $stable(dac_code_o));

  // R3: top saturation
  a_r3_sat_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_mode_i && !cmp_above_i && dac_code_o == 8'hFF) |=> (dac_code_o == 8'hFF));

  // R3: bottom saturation
  a_r3_sat_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_mode_i && cmp_above_i && dac_code_o == 8'h00) |=> (dac_code_o == 8'h00));

  // R5: permit only appears after a cool filtered reading
  a_r5_permit_cool: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_ok_o) |-> ($past(filt_fast) < 8'(REC_CODE)));

  // R6: the flag rises only on a hot filtered reading
  a_r6_fault_hot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ot_fault_o) |-> ($past(filt_fast) > 8'(SHUT_CODE)));

  // R6: the flag drops only below the recovery code
  a_r6_fault_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ot_fault_o) |-> ($past(filt_fast) < 8'(REC_CODE)));

  // R7: derating never raises the level
  a_r7_no_boost: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dim_o <= dim_i);
endmodule

bind thermal_track_derate thd_checker #(
  .DIM_W(DIM_W), .SHUT_CODE(SHUT_CODE), .REC_CODE(REC_CODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmp_above_i(cmp_above_i),
  .half_cyc_i(half_cyc_i), .fast_mode_i(fast_mode_i), .dim_i(dim_i),
  .dac_code_o(dac_code_o), .ot_fault_o(ot_fault_o), .run_ok_o(run_ok_o),
  .dim_o(dim_o), .filt_fast(filt_fast)
);

// File: tb/thermal_track_derate_test.sv
module thermal_track_derate_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIM_W = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic cmp, stb, fst;
  logic [DIM_W-1:0] dim;
  logic [7:0] dac;
  logic fault, run_ok;
  logic [DIM_W-1:0] dim_out;

  int checks = 0;
  int errors = 0;

  // reference state, from the requirement formulas
  int m_code, m_cnt, m_facc, m_sacc;
  bit m_started, m_fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_track_derate uut (
    .clk_i(clk), .rst_ni(rst_n), .cmp_above_i(cmp), .half_cyc_i(stb),
    .fast_mode_i(fst), .dim_i(dim), .dac_code_o(dac), .ot_fault_o(fault),
    .run_ok_o(run_ok), .dim_o(dim_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_ff();
    return m_facc >> 3;
  endfunction

  function automatic int m_ss();
    return m_sacc >> 8;
  endfunction

  function automatic int m_dim(input int d);
    int s, sc;
    s = m_ss();
    if (s <= 197) sc = 256;
    else if (s >= 242) sc = 128;
    else sc = 256 - (((s - 197) * 728) >> 8);
    return (d * sc) >> 8;
  endfunction

  task automatic m_reset();
    m_code = 0; m_cnt = 0; m_facc = 2047; m_sacc = 0;
    m_started = 0; m_fault = 0;
  endtask

  task automatic compare_all();
    chk("R1 code", int'(dac), m_code);
    chk("R6 fault", int'(fault), int'(m_fault));
    chk("R5 permit", int'(run_ok), int'(m_started & ~m_fault));
    chk("R7 dim", int'(dim_out), m_dim(int'(dim)));
  endtask

  // one clock: drive at negedge, update reference at posedge, compare at next negedge
  task automatic step(input bit c, input bit s, input bit f);
    bit tick;
    int ncode, ncnt, nfacc, nsacc, ff;
    bit nst, nfl;
    cmp = c; stb = s; fst = f;
    @(posedge clk);
    tick  = f | (s & (m_cnt == 6));
    ncnt  = f ? 0 : (s ? ((m_cnt == 6) ? 0 : m_cnt + 1) : m_cnt);
    ncode = m_code;
    if (tick) ncode = c ? ((m_code > 0) ? m_code - 1 : 0) : ((m_code < 255) ? m_code + 1 : 255);
    nfacc = tick ? (m_facc + m_code - (m_facc >> 3)) : m_facc;
    nsacc = s ? (m_sacc + m_code - (m_sacc >> 8)) : m_sacc;
    ff  = m_ff();
    nst = m_started | (ff < 222);
    nfl = (m_started && ff > 250) ? 1'b1 : ((ff < 222) ? 1'b0 : m_fault);
    m_code = ncode; m_cnt = ncnt; m_facc = nfacc; m_sacc = nsacc;
    m_started = nst; m_fault = nfl;
    @(negedge clk);
    compare_all();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cmp = 0; stb = 0; fst = 0; dim = 10'd600;
    m_reset();
    repeat (3) @(negedge clk);
    chk("R8 code after reset", int'(dac), 0);
    chk("R8 fault after reset", int'(fault), 0);
    chk("R8 permit after reset", int'(run_ok), 0);
    chk("R8 dim passthrough", int'(dim_out), 600);
    rst_n = 1'b1;
  endtask

  task automatic t_fast_track();
    step(0, 0, 1);
    chk("R5 no permit on first update", int'(run_ok), 0);
    for (int i = 0; i < 9; i++) step(0, 0, 1);
    chk("R2 fast mode one step per clock", int'(dac), 10);
    chk("R5 permit after cool reading", int'(run_ok), 1);
  endtask

  task automatic t_normal_div();
    int base;
    base = int'(dac);
    for (int i = 0; i < 6; i++) begin
      step(0, 1, 0);
      step(0, 0, 0);
      step(0, 0, 0);
    end
    chk("R2 six strobes hold code", int'(dac), base);
    step(0, 1, 0);
    chk("R2 seventh strobe steps up", int'(dac), base + 1);
    for (int i = 0; i < 5; i++) step(0, 0, 0);
    chk("R2 idle clocks hold code", int'(dac), base + 1);
  endtask

  task automatic t_decrement();
    int base;
    base = int'(dac);
    for (int i = 0; i < 7; i++) step(1, 1, 0);
    chk("R1 comparator high steps down", int'(dac), base - 1);
  endtask

  task automatic t_sat_high();
    for (int i = 0; i < 300; i++) step(0, 0, 1);
    chk("R3 saturates at 255", int'(dac), 255);
    chk("R6 fault at full scale", int'(fault), 1);
    chk("R5 permit dropped by fault", int'(run_ok), 0);
  endtask

  task automatic t_hysteresis();
    bit seen_band = 0;
    bit cleared = 0;
    for (int i = 0; i < 150; i++) begin
      step(1, 0, 1);
      if (!seen_band && m_ff() >= 222 && m_ff() <= 250) begin
        seen_band = 1;
        chk("R6 fault held inside band", int'(fault), 1);
        chk("R6 tracking continues during fault", int'(dac < 8'd255), 1);
      end
      if (!cleared && !fault) cleared = 1;
    end
    chk("R6 band was crossed", int'(seen_band), 1);
    chk("R6 fault cleared below recovery", int'(cleared), 1);
    chk("R5 permit back after fault", int'(run_ok), 1);
  endtask

  task automatic t_sat_low();
    for (int i = 0; i < 300; i++) step(1, 0, 1);
    chk("R3 saturates at 0", int'(dac), 0);
    for (int i = 0; i < 5; i++) step(1, 1, 0);
    for (int i = 0; i < 2; i++) step(1, 1, 0);
    chk("R3 stays at 0 after normal step", int'(dac), 0);
  endtask

  task automatic t_derate();
    bit mid_done = 0;
    dim = 10'd1000;
    for (int i = 0; i < 150; i++) step(0, 1, 1);
    chk("R7 below knee passes request", int'(dim_out), 1000);
    for (int i = 0; i < 1000; i++) begin
      step(0, 1, 1);
      if (!mid_done && m_ss() >= 210 && m_ss() < 242) begin
        mid_done = 1;
        chk("R7 ramp below request", int'(dim_out < 10'd1000), 1);
        chk("R7 ramp above half", int'(dim_out > 10'd500), 1);
      end
    end
    chk("R7 ramp region reached", int'(mid_done), 1);
    chk("R4 slow filter past end code", int'(m_ss() >= 242), 1);
    chk("R7 floor at half", int'(dim_out), 500);
    dim = 10'd1023;
    #1 chk("R7 floor full-scale request", int'(dim_out), 511);
    dim = 10'd0;
    #1 chk("R7 zero request", int'(dim_out), 0);
    dim = 10'd7;
    #1 chk("R7 small request", int'(dim_out), 3);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fast_track();
    t_normal_div();
    t_decrement();
    t_sat_high();
    t_hysteresis();
    t_sat_low();
    t_derate();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule